// File: doc/BRIEF.md
# Breakpoint Trigger Reentrancy Qualifier

This block sits between the raw comparators of a hardware debug trigger and the logic that raises the trigger's action. When the trigger is set to raise a breakpoint exception, a hit could land inside the handler that services that same exception. If that handler runs with its interrupt enable cleared, the second exception would overwrite the saved state of the first. The qualifier looks at the current privilege level, the virtualization flag, the interrupt-enable bit at each level and the breakpoint delegation bits. From these it decides whether the exception may be taken, and it drops the hit when it may not.

Three raw sources pass through the same gate: a load/store address or data comparison, an instruction-count expiry, and a trap-type trigger. The trap source is decoded inside the block from the cause word of the trap being taken and from two selection masks, one for interrupts and one for exceptions. A qualified trap hit also drives a flag that says the action fires after the trap. Every output is combinational, so a qualified hit appears in the same cycle as its raw match.

Top module: `ntg_gate`

## Requirements
- R1: When the action code is non-zero, each qualified hit equals its raw match, whatever the privilege, virtualization, enable and delegation inputs are.
- R2: With action code 0 at privilege code 3 (machine), every hit is suppressed while `mie` is 0 and allowed while `mie` is 1.
- R3: With action code 0 at privilege code 1 and `virt` 0, hits are suppressed only when `medeleg_bkpt` is 1 and `sie` is 0.
- R4: With action code 0 at privilege code 1 and `virt` 1, hits are suppressed only when `medeleg_bkpt`, `hedeleg_bkpt` are both 1 and `vsie` is 0.
- R5: With action code 0 at privilege code 0 (user) or the reserved code 2, hits are never suppressed.
- R6: No qualified hit is ever raised without its raw match. With all inputs at 0, every output is 0.
- R7: The raw trap match is `trap_valid` AND a selected mask bit. Bit XLEN-1 of `trap_cause` picks the mask: 1 picks `trap_int_sel`, 0 picks `trap_exc_sel`. Bits XLEN-2:0 are the index into that mask. An index of XLEN or more never matches.
- R8: `trap_after` is 1 exactly when `hit_trap` is 1.
- R9: Outputs follow their inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| virt | input | 1 | Virtualization mode active |
| mie | input | 1 | Machine-level global interrupt enable |
| sie | input | 1 | Supervisor-level global interrupt enable |
| vsie | input | 1 | Virtual-supervisor global interrupt enable |
| medeleg_bkpt | input | 1 | Breakpoint cause (3) delegated out of machine level |
| hedeleg_bkpt | input | 1 | Breakpoint cause (3) delegated further to the guest |
| action | input | ACT_W | Trigger action code; 0 means breakpoint exception |
| raw_mem | input | 1 | Raw address/data comparator match |
| raw_icnt | input | 1 | Raw instruction-count expiry |
| trap_valid | input | 1 | A trap is being taken this cycle |
| trap_cause | input | XLEN | Cause word of that trap |
| trap_int_sel | input | XLEN | Interrupt indices the trap trigger watches |
| trap_exc_sel | input | XLEN | Exception indices the trap trigger watches |
| hit_mem | output | 1 | Qualified address/data hit |
| hit_icnt | output | 1 | Qualified instruction-count hit |
| hit_trap | output | 1 | Qualified trap hit |
| trap_after | output | 1 | Trap hit fires after the trap |

## Verification
The bench builds two copies of the block, one with XLEN 64 and one with XLEN 32, and a 4-bit action field. Both widths place the interrupt flag at a different bit, and in each copy the random trap indices run past XLEN. This covers the last valid index and the first out-of-range index for each width. The 4-bit action field lets random codes reach many non-zero values as well as 0, so the pass-through path and the gated path are both covered.

// File: rtl/ntg_pkg.sv
package ntg_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // Interrupt-enable and delegation view used by the reentrancy policy.
  typedef struct packed {
    logic mie;
    logic sie;
    logic vsie;
    logic m_deleg;
    logic h_deleg;
  } irq_ctx_t;

  // One term per level: a level blocks only if the breakpoint would be
  // handled there and that level's handler has interrupts masked.
  function automatic logic reentry_ok(priv_e p, logic v, irq_ctx_t c);
    logic m_term, hs_term, vs_term;
    m_term  = (p != PRIV_M) || c.mie;
    hs_term = (p != PRIV_S) || v || !c.m_deleg || c.sie;
    vs_term = (p != PRIV_S) || !v || !c.m_deleg || !c.h_deleg || c.vsie;
    return m_term && hs_term && vs_term;
  endfunction
endpackage

// File: rtl/ntg_mode_policy.sv
module ntg_mode_policy
  import ntg_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  irq_ctx_t   ctx,
  output logic       allow
);
  priv_e level;
  assign level = priv_e'(priv);
  assign allow = reentry_ok(level, virt, ctx);
endmodule

// File: rtl/ntg_trap_decode.sv
module ntg_trap_decode #(
  parameter int XLEN = 64
) (
  input  logic            valid,
  input  logic [XLEN-1:0] cause,
  input  logic [XLEN-1:0] int_sel,
  input  logic [XLEN-1:0] exc_sel,
  output logic            raw_hit,
  output logic            in_range
);
  localparam int IDXW = $clog2(XLEN);

  logic            is_int;
  logic [XLEN-2:0] idx_full;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] mask;

  assign is_int   = cause[XLEN-1];
  assign idx_full = cause[XLEN-2:0];
  assign in_range = (idx_full < (XLEN-1)'(XLEN));
  assign idx      = idx_full[IDXW-1:0];
  assign mask     = is_int ? int_sel : exc_sel;
  assign raw_hit  = valid && in_range && mask[idx];

  always_comb begin
    if (!in_range) AST_IDX_RANGE: assert (!raw_hit); // R7
    if (!valid) AST_TRAP_IDLE: assert (!raw_hit); // R7
  end
endmodule

// File: rtl/ntg_qualify.sv
module ntg_qualify #(
  parameter int ACT_W = 4
) (
  input  logic [ACT_W-1:0] action,
  input  logic             allow,
  input  logic             raw_mem,
  input  logic             raw_icnt,
  input  logic             raw_trap,
  output logic             hit_mem,
  output logic             hit_icnt,
  output logic             hit_trap,
  output logic             trap_after
);
  localparam logic [ACT_W-1:0] ACT_BKPT = '0;

  logic gate_open;
  logic [2:0] raw_vec, hit_vec;

  assign gate_open = (action != ACT_BKPT) || allow;
  assign raw_vec   = {raw_trap, raw_icnt, raw_mem};

  for (genvar g = 0; g < 3; g++) begin : g_src
    assign hit_vec[g] = raw_vec[g] && gate_open;
  end

  assign hit_mem    = hit_vec[0];
  assign hit_icnt   = hit_vec[1];
  assign hit_trap   = hit_vec[2];
  assign trap_after = hit_vec[2];
endmodule

// File: rtl/ntg_gate.sv
module ntg_gate
  import ntg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ACT_W = 4
) (
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             mie,
  input  logic             sie,
  input  logic             vsie,
  input  logic             medeleg_bkpt,
  input  logic             hedeleg_bkpt,
  input  logic [ACT_W-1:0] action,
  input  logic             raw_mem,
  input  logic             raw_icnt,
  input  logic             trap_valid,
  input  logic [XLEN-1:0]  trap_cause,
  input  logic [XLEN-1:0]  trap_int_sel,
  input  logic [XLEN-1:0]  trap_exc_sel,
  output logic             hit_mem,
  output logic             hit_icnt,
  output logic             hit_trap,
  output logic             trap_after
);
  irq_ctx_t ctx;
  logic     allow;
  logic     trap_raw;
  logic     trap_in_range;

  assign ctx = '{mie: mie, sie: sie, vsie: vsie,
                 m_deleg: medeleg_bkpt, h_deleg: hedeleg_bkpt};

  ntg_mode_policy u_policy (
    .priv (priv),
    .virt (virt),
    .ctx  (ctx),
    .allow(allow)
  );

  ntg_trap_decode #(.XLEN(XLEN)) u_trap (
    .valid   (trap_valid),
    .cause   (trap_cause),
    .int_sel (trap_int_sel),
    .exc_sel (trap_exc_sel),
    .raw_hit (trap_raw),
    .in_range(trap_in_range)
  );

  ntg_qualify #(.ACT_W(ACT_W)) u_qual (
    .action    (action),
    .allow     (allow),
    .raw_mem   (raw_mem),
    .raw_icnt  (raw_icnt),
    .raw_trap  (trap_raw),
    .hit_mem   (hit_mem),
    .hit_icnt  (hit_icnt),
    .hit_trap  (hit_trap),
    .trap_after(trap_after)
  );

  logic bkpt_act;
  assign bkpt_act = (action == '0);

  always_comb begin
    if (!bkpt_act)
      AST_PASSTHRU: assert (hit_mem == raw_mem && hit_icnt == raw_icnt && hit_trap == trap_raw); // R1
    if (bkpt_act && priv == 2'd3 && !mie)
      AST_M_MASK: assert (!hit_mem && !hit_icnt && !hit_trap); // R2
    if (bkpt_act && priv == 2'd1 && !virt && medeleg_bkpt && !sie)
      AST_S_MASK: assert (!hit_mem && !hit_icnt && !hit_trap); // R3
    if (bkpt_act && priv == 2'd1 && virt && medeleg_bkpt && hedeleg_bkpt && !vsie)
      AST_VS_MASK: assert (!hit_mem && !hit_icnt && !hit_trap); // R4
    if (priv == 2'd0 || priv == 2'd2)
      AST_USER_OPEN: assert (hit_mem == raw_mem && hit_icnt == raw_icnt && hit_trap == trap_raw); // R5
    AST_NO_SPURIOUS: assert ((!hit_mem || raw_mem) && (!hit_icnt || raw_icnt) && (!hit_trap || trap_raw)); // R6
    if (hit_trap)
      AST_TRAP_SRC: assert (trap_valid && trap_in_range); // R7
    AST_AFTER_FLAG: assert (trap_after == hit_trap); // R8
  end
endmodule

// File: tb/ntg_gate_bench.sv
module ntg_gate_bench;
  localparam int ACT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]       priv;
  logic             virt, mie, sie, vsie, md, hd;
  logic [ACT_W-1:0] action;
  logic             raw_mem, raw_icnt, tv;
  logic [63:0]      c64, is64, es64;
  logic [31:0]      c32, is32, es32;
  logic             hm, hi, ht, ta, hm32, hi32, ht32, ta32;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  ntg_gate #(.XLEN(64), .ACT_W(ACT_W)) u_ntg_gate (
    .priv(priv), .virt(virt), .mie(mie), .sie(sie), .vsie(vsie),
    .medeleg_bkpt(md), .hedeleg_bkpt(hd), .action(action),
    .raw_mem(raw_mem), .raw_icnt(raw_icnt), .trap_valid(tv),
    .trap_cause(c64), .trap_int_sel(is64), .trap_exc_sel(es64),
    .hit_mem(hm), .hit_icnt(hi), .hit_trap(ht), .trap_after(ta));

  ntg_gate #(.XLEN(32), .ACT_W(ACT_W)) u_ntg_gate32 (
    .priv(priv), .virt(virt), .mie(mie), .sie(sie), .vsie(vsie),
    .medeleg_bkpt(md), .hedeleg_bkpt(hd), .action(action),
    .raw_mem(raw_mem), .raw_icnt(raw_icnt), .trap_valid(tv),
    .trap_cause(c32), .trap_int_sel(is32), .trap_exc_sel(es32),
    .hit_mem(hm32), .hit_icnt(hi32), .hit_trap(ht32), .trap_after(ta32));

  // Expected permission, written as a decision per level.
  function automatic bit exp_allow();
    if (action != 0) return 1;
    case (priv)
      2'd3: return mie;
      2'd1: if (!virt) return !md || sie;
            else return !(md && hd) || vsie;
      default: return 1;
    endcase
  endfunction

  function automatic string req_tag();
    if (action != 0) return "R1";
    case (priv)
      2'd3: return "R2";
      2'd1: return virt ? "R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  function automatic bit exp_trap64();
    longint unsigned idx = {1'b0, c64[62:0]};
    if (!tv || idx >= 64) return 0;
    return c64[63] ? is64[idx] : es64[idx];
  endfunction

  function automatic bit exp_trap32();
    int unsigned idx = {1'b0, c32[30:0]};
    if (!tv || idx >= 32) return 0;
    return c32[31] ? is32[idx] : es32[idx];
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit al = exp_allow();
    string t = req_tag();
    bit t64 = exp_trap64();
    bit t32 = exp_trap32();
    check(raw_mem ? t : "R6", "hit_mem", hm, raw_mem && al);
    check(raw_icnt ? t : "R6", "hit_icnt", hi, raw_icnt && al);
    check(t64 ? t : "R7", "hit_trap", ht, t64 && al);
    check("R8", "trap_after", ta, t64 && al);
    check(t32 ? t : "R7", "hit_trap32", ht32, t32 && al);
    check("R8", "trap_after32", ta32, t32 && al);
    check(raw_mem ? t : "R6", "hit_mem32", hm32, raw_mem && al);
  endtask

  task automatic clear();
    priv = 0; virt = 0; mie = 0; sie = 0; vsie = 0; md = 0; hd = 0;
    action = 0; raw_mem = 0; raw_icnt = 0; tv = 0;
    c64 = 0; is64 = 0; es64 = 0; c32 = 0; is32 = 0; es32 = 0;
  endtask

  // R9: inputs change after a rising edge, outputs are sampled at the
  // following falling edge, with no clock edge that could register them.
  task automatic step();
    @(negedge clk);
    check_all();
    @(posedge clk);
    #1;
  endtask

  task automatic all_raw();
    raw_mem = 1; raw_icnt = 1; tv = 1;
    c64 = 64'd3; es64 = '1; c32 = 32'd3; es32 = '1;
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R6 idle state: all zero inputs give no hits.
    step();
    if (hm || hi || ht || ta) begin n_fail++; $display("FAIL R6 idle outputs not zero"); end
    n_tests++;
    // R2 machine level masked then enabled.
    all_raw(); priv = 3; mie = 0; step();
    mie = 1; step();
    // R3 supervisor, delegated, masked; then not delegated.
    priv = 1; mie = 0; md = 1; sie = 0; step();
    md = 0; step();
    // R4 guest, doubly delegated and masked; then hedeleg clear.
    virt = 1; md = 1; hd = 1; vsie = 0; sie = 1; step();
    hd = 0; step();
    // R5 user and reserved code with everything masked.
    md = 1; hd = 1; sie = 0; vsie = 0; priv = 0; step();
    priv = 2; step();
    // R1 non-breakpoint action at masked machine level.
    priv = 3; action = 4'd1; step();
    // R7 interrupt flag selects other mask; index boundaries.
    action = 0; priv = 0; es64 = 0; is64 = 64'h8000_0000_0000_0000;
    c64 = {1'b1, 63'd63}; step();
    c64 = {1'b1, 63'd64}; is64 = '1; step();
    es32 = 0; is32 = 32'h8000_0000; c32 = {1'b1, 31'd31}; step();
    c32 = {1'b1, 31'd32}; is32 = '1; step();

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      priv = 2'($urandom); virt = 1'($urandom); mie = 1'($urandom);
      sie = 1'($urandom); vsie = 1'($urandom); md = 1'($urandom);
      hd = 1'($urandom);
      action = ($urandom % 2 == 0) ? '0 : ACT_W'($urandom);
      raw_mem = 1'($urandom); raw_icnt = 1'($urandom); tv = 1'($urandom);
      c64 = {1'($urandom), 63'($urandom % 72)};
      is64 = {$urandom, $urandom}; es64 = {$urandom, $urandom};
      c32 = {1'($urandom), 31'($urandom % 40)};
      is32 = $urandom; es32 = $urandom;
      step();
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule